// File: doc/BRIEF.md
# Load-Linked Reservation Filter

This block sits beside a CPU's load/store unit. It keeps one reservation per CPU: a valid flag and a granule-aligned physical address. A completed load-linked operation sets the flag and records the address. Each store-conditional is checked against the reservation in the cycle it is presented. A store-conditional that has no chance of succeeding is never sent to memory. Instead it gets an immediate failure code, and the reservation is dropped.

Store-conditionals to uncacheable space skip the check entirely. They are always forwarded, and they carry a code telling the writeback stage to leave the destination register untouched. Locally rejected store-conditionals are counted as a run of consecutive failures. The count returns to zero when a store-conditional completes at memory with a nonzero result. A one-cycle warning pulse marks every `WARN_PERIOD` failures in a row, so that livelock can be spotted. The count saturates at its maximum value.

Top module: `ll_lock_monitor`

## Requirements
- R1: When `ll_done` is high at a clock edge, the reservation becomes valid and holds `ll_addr` with its low `GRAN_BITS` bits cleared (bits [3:0] by default). Any later store-conditional whose address falls in the same granule passes the check.
- R2: A cacheable store-conditional (`sc_req`=1, `sc_uncached`=0) whose masked address matches a valid reservation gives `sc_issue`=1, `sc_local_fail`=0 and `sc_code`=1 (forwarded, result comes from memory). These outputs are combinational in the same cycle.
- R3: A cacheable store-conditional that finds the reservation invalid, or finds a different granule, gives `sc_issue`=0, `sc_local_fail`=1 and `sc_code`=0. The reservation is invalid from the next cycle on.
- R4: An uncacheable store-conditional gives `sc_issue`=1, `sc_local_fail`=0 and `sc_code`=2 (leave destination unchanged), whatever the reservation holds. It changes neither the reservation nor `fail_count`.
- R5: Each local failure adds one to `fail_count` at the next edge. At all ones (`2**CNT_W-1`) the count holds.
- R6: `warn_pulse` is high for exactly the one cycle in which `fail_count` has just stepped to a nonzero multiple of `WARN_PERIOD`. A saturated count raises no further pulse.
- R7: `sc_resp_valid`=1 with `sc_resp_ok`=1 sets `fail_count` to 0. If a local failure occurs in the same cycle, the response is taken as older, and the count becomes 1.
- R8: When `ll_done` and a store-conditional fall in the same cycle, the store-conditional is judged on the reservation as it stood before that cycle. The new load-linked reservation is the one kept afterwards.
- R9: After reset the reservation is invalid, `fail_count` is 0 and `warn_pulse` is 0. With no `sc_req`, `sc_issue` and `sc_local_fail` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_done | input | 1 | Pulse: a load-linked has completed |
| ll_addr | input | ADDR_W | Physical address of that load-linked |
| sc_req | input | 1 | A store-conditional is presented this cycle |
| sc_addr | input | ADDR_W | Physical address of the store-conditional |
| sc_uncached | input | 1 | Store-conditional targets uncacheable space |
| sc_resp_valid | input | 1 | A forwarded store-conditional has completed at memory |
| sc_resp_ok | input | 1 | That completion carried a nonzero result |
| sc_issue | output | 1 | Forward the store-conditional to memory |
| sc_local_fail | output | 1 | Store-conditional rejected locally |
| sc_code | output | 2 | Early result: 0 fail, 1 forwarded, 2 keep destination |
| fail_count | output | CNT_W | Consecutive local failures, saturating |
| warn_pulse | output | 1 | Livelock warning pulse |

## Verification
Two pairs of functions can land in the same cycle. A load-linked completion can coincide with a store-conditional, which exercises the ordering of R8. A memory success response can coincide with a new local failure, which exercises R7. Directed cycles force each collision on purpose. A random phase then overlaps them freely over a few granules, so that hits, misses and uncacheable requests mix. A behavioural model in the bench uses plain integers and the `%` operator. It predicts the issue decision, the code, the count and the warning, and it is compared with the design on every clock.

// File: rtl/llm_pkg.sv
package llm_pkg;
   typedef enum logic [1:0] {
      SC_REJECT  = 2'd0,
      SC_FORWARD = 2'd1,
      SC_KEEPDST = 2'd2
   } sc_code_e;
endpackage

// File: rtl/llm_lock_reg.sv
module llm_lock_reg #(
   parameter int ADDR_W    = 40,
   parameter int GRAN_BITS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_i,
   input  logic [ADDR_W-1:0] set_addr_i,
   input  logic              drop_i,
   input  logic [ADDR_W-1:0] probe_addr_i,
   output logic              hit_o
);
   localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << GRAN_BITS) - 64'd1);

   initial assert (GRAN_BITS >= 0 && GRAN_BITS < ADDR_W)
      else $error("llm_lock_reg: GRAN_BITS out of range");

   logic              valid_q;
   logic [ADDR_W-1:0] granule_q;
   logic [ADDR_W-1:0] set_gran, probe_gran;

   assign set_gran   = set_addr_i & ~LOW_MASK;
   assign probe_gran = probe_addr_i & ~LOW_MASK;
   assign hit_o      = valid_q && (probe_gran == granule_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q   <= 1'b0;
         granule_q <= '0;
      end else if (set_i) begin
         valid_q   <= 1'b1;
         granule_q <= set_gran;
      end else if (drop_i) begin
         valid_q   <= 1'b0;
      end
   end

   assert_ll_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> valid_q && (granule_q == ($past(set_addr_i) & ~LOW_MASK)));

   assert_drop_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_i && !set_i) |=> !valid_q);

   assert_granule_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !set_i |=> $stable(granule_q));
endmodule

// File: rtl/llm_fail_track.sv
module llm_fail_track #(
   parameter int CNT_W       = 32,
   parameter int WARN_PERIOD = 100000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fail_i,
   input  logic             clear_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             warn_o
);
   localparam int               MOD_W   = (WARN_PERIOD > 1) ? $clog2(WARN_PERIOD) : 1;
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam bit               IS_POW2 = ((WARN_PERIOD & (WARN_PERIOD - 1)) == 0);

   initial assert (WARN_PERIOD >= 2 && MOD_W <= CNT_W &&
                   longint'(WARN_PERIOD) <= ((longint'(1) << CNT_W) - 1))
      else $error("llm_fail_track: WARN_PERIOD does not fit CNT_W");

   logic [CNT_W-1:0] cnt_q, base_cnt, next_cnt;
   logic             warn_q, step, wrap;

   assign base_cnt = clear_i ? '0 : cnt_q;
   assign step     = fail_i && (base_cnt != CNT_MAX);
   assign next_cnt = step ? base_cnt + 1'b1 : base_cnt;

   generate
      if (IS_POW2) begin : g_pow2
         assign wrap = &base_cnt[MOD_W-1:0];
      end else begin : g_modctr
         logic [MOD_W-1:0] mod_q, base_mod;
         assign base_mod = clear_i ? '0 : mod_q;
         assign wrap     = (base_mod == MOD_W'(WARN_PERIOD - 1));
         always_ff @(posedge clk) begin
            if (!rst_n)    mod_q <= '0;
            else if (step) mod_q <= wrap ? '0 : base_mod + 1'b1;
            else           mod_q <= base_mod;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         warn_q <= 1'b0;
      end else begin
         cnt_q  <= next_cnt;
         warn_q <= step && wrap;
      end
   end

   assign cnt_o  = cnt_q;
   assign warn_o = warn_q;

   assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_i && !clear_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);

   assert_count_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);

   assert_warn_multiple_R6: assert property (@(posedge clk) disable iff (!rst_n)
      warn_q |-> (cnt_q != '0) && ((longint'(cnt_q) % WARN_PERIOD) == 0));

   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> cnt_q <= CNT_W'(1));
endmodule

// File: rtl/ll_lock_monitor.sv
module ll_lock_monitor #(
   parameter int ADDR_W      = 40,
   parameter int GRAN_BITS   = 4,
   parameter int CNT_W       = 32,
   parameter int WARN_PERIOD = 100000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ll_done,
   input  logic [ADDR_W-1:0] ll_addr,
   input  logic              sc_req,
   input  logic [ADDR_W-1:0] sc_addr,
   input  logic              sc_uncached,
   input  logic              sc_resp_valid,
   input  logic              sc_resp_ok,
   output logic              sc_issue,
   output logic              sc_local_fail,
   output logic [1:0]        sc_code,
   output logic [CNT_W-1:0]  fail_count,
   output logic              warn_pulse
);
   import llm_pkg::*;

   logic     resv_hit, reject;
   sc_code_e code;

   llm_lock_reg #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS)) u_resv (
      .clk          (clk),
      .rst_n        (rst_n),
      .set_i        (ll_done),
      .set_addr_i   (ll_addr),
      .drop_i       (reject),
      .probe_addr_i (sc_addr),
      .hit_o        (resv_hit)
   );

   always_comb begin
      reject = 1'b0;
      code   = SC_REJECT;
      if (sc_req) begin
         if (sc_uncached)   code = SC_KEEPDST;
         else if (resv_hit) code = SC_FORWARD;
         else               reject = 1'b1;
      end
   end

   assign sc_issue      = sc_req && !reject;
   assign sc_local_fail = reject;
   assign sc_code       = code;

   llm_fail_track #(.CNT_W(CNT_W), .WARN_PERIOD(WARN_PERIOD)) u_fails (
      .clk     (clk),
      .rst_n   (rst_n),
      .fail_i  (reject),
      .clear_i (sc_resp_valid && sc_resp_ok),
      .cnt_o   (fail_count),
      .warn_o  (warn_pulse)
   );

   assert_uncached_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_req && sc_uncached) |-> sc_issue && !sc_local_fail && sc_code == 2'd2);

   assert_reject_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sc_local_fail |-> !sc_issue && sc_code == 2'd0);

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !sc_req |-> !sc_issue && !sc_local_fail);

   assert_ll_then_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ll_done && sc_req && !sc_uncached && $stable(sc_addr)) |=>
         (sc_req && !sc_uncached && $stable(sc_addr) && $stable(ll_addr) &&
          ll_addr == sc_addr) ? sc_issue : 1'b1);
endmodule

// File: tb/ll_lock_monitor_tb.sv
`timescale 1ns/100ps
module ll_lock_monitor_tb;
   localparam int AW   = 16;
   localparam int CW   = 4;
   localparam int PER  = 5;
   localparam int CMAX = (1 << CW) - 1;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          ll_done = 0, sc_req = 0, sc_uncached = 0, sc_resp_valid = 0, sc_resp_ok = 0;
   logic [AW-1:0] ll_addr = '0, sc_addr = '0;
   logic          sc_issue, sc_local_fail, warn_pulse;
   logic [1:0]    sc_code;
   logic [CW-1:0] fail_count;

   int tests = 0, fails = 0;
   bit done = 0;

   // behavioural reference
   bit m_flag = 0;
   int m_gran = 0;
   int m_cnt  = 0;
   bit m_warn = 0;

   always #2.5 clk = ~clk;

   ll_lock_monitor #(.ADDR_W(AW), .GRAN_BITS(4), .CNT_W(CW), .WARN_PERIOD(PER)) u_dut (
      .clk(clk), .rst_n(rst_n), .ll_done(ll_done), .ll_addr(ll_addr),
      .sc_req(sc_req), .sc_addr(sc_addr), .sc_uncached(sc_uncached),
      .sc_resp_valid(sc_resp_valid), .sc_resp_ok(sc_resp_ok),
      .sc_issue(sc_issue), .sc_local_fail(sc_local_fail), .sc_code(sc_code),
      .fail_count(fail_count), .warn_pulse(warn_pulse));

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic cyc(input bit ll, input int lla, input bit sc, input int sca,
                      input bit unc, input bit rv, input bit rok, input string tag);
      bit    hit, e_issue, e_fail, clr;
      int    e_code, base;
      string t, ct;
      @(negedge clk);
      ll_done = ll; ll_addr = AW'(lla); sc_req = sc; sc_addr = AW'(sca);
      sc_uncached = unc; sc_resp_valid = rv; sc_resp_ok = rok;
      #1;
      hit     = m_flag && ((sca & ~15) == m_gran);
      e_issue = sc && (unc || hit);
      e_fail  = sc && !unc && !hit;
      e_code  = !sc ? 0 : unc ? 2 : hit ? 1 : 0;
      if (tag != "")      t = tag;
      else if (ll && sc)  t = "R8";
      else if (!sc)       t = "R9";
      else if (unc)       t = "R4";
      else if (hit)       t = "R2";
      else                t = "R3";
      chk(sc_issue == e_issue, t, "sc_issue", sc_issue, e_issue);
      chk(sc_local_fail == e_fail, t, "sc_local_fail", sc_local_fail, e_fail);
      if (sc) chk(sc_code == 2'(e_code), t, "sc_code", sc_code, e_code);
      clr  = rv && rok;
      base = clr ? 0 : m_cnt;
      if (e_fail && base < CMAX) begin
         m_cnt  = base + 1;
         m_warn = (m_cnt % PER) == 0;
      end else begin
         m_cnt  = base;
         m_warn = 0;
      end
      if (ll) begin
         m_flag = 1; m_gran = lla & ~15;
      end else if (e_fail) m_flag = 0;
      @(posedge clk); #1;
      ct = clr ? "R7" : "R5";
      chk(fail_count == CW'(m_cnt), ct, "fail_count", fail_count, m_cnt);
      chk(warn_pulse == m_warn, "R6", "warn_pulse", warn_pulse, m_warn);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      chk(fail_count == 0, "R9", "reset fail_count", fail_count, 0);
      chk(warn_pulse == 0, "R9", "reset warn_pulse", warn_pulse, 0);
      // no reservation after reset
      cyc(0, 0, 1, 'h0000, 0, 0, 0, "R9");
      cyc(0, 0, 0, 0, 0, 0, 0, "R9");
      // granule capture
      cyc(1, 'h1234, 0, 0, 0, 0, 0, "R1");
      cyc(0, 0, 1, 'h123F, 0, 0, 0, "R1");
      cyc(0, 0, 1, 'h1230, 0, 0, 0, "R2");
      cyc(0, 0, 1, 'h1240, 0, 0, 0, "R3");
      cyc(0, 0, 1, 'h1234, 0, 0, 0, "R3");
      // uncacheable bypass, flag clear and flag set
      cyc(0, 0, 1, 'h5555, 1, 0, 0, "R4");
      cyc(1, 'h0040, 0, 0, 0, 0, 0, "R1");
      cyc(0, 0, 1, 'h0999, 1, 0, 0, "R4");
      cyc(0, 0, 1, 'h0044, 0, 0, 0, "R2");
      // response clears; response colliding with a reject
      cyc(0, 0, 0, 0, 0, 1, 1, "R7");
      cyc(0, 0, 1, 'h0800, 0, 0, 0, "R3");
      cyc(0, 0, 1, 'h0800, 0, 1, 1, "R7");
      cyc(0, 0, 0, 0, 0, 1, 0, "R7");
      // run into saturation with periodic warnings
      for (int i = 0; i < 18; i++) cyc(0, 0, 1, 'h0700, 0, 0, 0, "R5");
      cyc(0, 0, 1, 'h0700, 0, 1, 1, "R7");
      // load-linked colliding with a store-conditional
      cyc(1, 'h0A00, 1, 'h0A00, 0, 0, 0, "R8");
      cyc(0, 0, 1, 'h0A08, 0, 0, 0, "R8");
      cyc(1, 'h0B00, 1, 'h0A00, 0, 0, 0, "R8");
      cyc(0, 0, 1, 'h0B0C, 0, 0, 0, "R8");
      // mixed random traffic over a few granules
      for (int i = 0; i < 600; i++) begin
         int  a1, a2;
         bit  ll, sc, unc, rv;
         a1  = (($urandom % 3) << 4) | ($urandom % 16);
         a2  = (($urandom % 3) << 4) | ($urandom % 16);
         ll  = ($urandom % 4) == 0;
         sc  = ($urandom % 2) == 0;
         unc = ($urandom % 8) == 0;
         rv  = ($urandom % 6) == 0;
         cyc(ll, a1, sc, a2, unc, rv, 1'($urandom % 2), "");
      end
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule